// File: doc/BRIEF.md
# Audio DMA control register bank

This block is the register front end for one direction of an audio stream mover, memory-to-stream or stream-to-memory. A simple 32-bit read/write port with byte addresses reaches a control word, a sticky status word, a fixed core configuration word, a set of plain setup registers, a transfer byte counter and a window of captured channel-status words. The control word drives the transfer engine directly: run enable, a soft-reset indication, two interrupt enables, a sample-width code and an active channel count.

The engine reports back with single-cycle pulses. A period-done pulse raises a sticky flag. Software clears that flag by writing one to it. While the flag is set and its enable bit is set, the block raises a level interrupt. A channel-status pulse latches the incoming status words and marks them valid. Each transfer step pulse adds its byte count to the transfer counter.

A soft reset is run by a two-state sequencer with the states SEQ_IDLE and SEQ_RESET. The transition SEQ_IDLE to SEQ_RESET happens when a control write sets bit 1. The transition SEQ_RESET to SEQ_IDLE happens after RST_CYCLES clocks. While the sequencer is in SEQ_RESET, the reset bit reads as 1, and the enable bit, the status flags and the transfer counter are held clear. Setup fields are kept.

Top module: `audio_dma_regbank`

## Requirements
- R1: After rst_n is released, control (0x10) and status (0x14) read 0x0000_0000, and eng_enable, eng_reset and irq are 0.
- R2: Offset 0x04 reads a constant built from the parameters, and writes to it have no effect. The field layout is:
  - bit 31: stream-to-memory path present
  - bits 30:29: its transfer mode
  - bit 28: its non-interleaved packing
  - bits 27:24: its maximum channel count
  - bit 15: memory-to-stream path present
  - bits 14:13: its transfer mode
  - bit 12: its non-interleaved packing
  - bits 11:8: its maximum channel count
- R3: Writing 1 to control bit 1 starts a soft reset. Bit 1 and eng_reset then read 1 for exactly RST_CYCLES clocks after the write edge and then clear by themselves.
- R4: A soft reset clears the enable bit, both status flags and the transfer count, and it ignores period-done pulses and enable writes while it runs. It keeps the interrupt enables, the width code, the channel count and the setup registers.
- R5: Status bit 31 is set by a period_done pulse and stays set until a write to 0x14 with bit 31 = 1. A write with bit 31 = 0 leaves it set, and a pulse in the same cycle as the clearing write wins.
- R6: irq is 1 exactly while status bit 31 and control bit 13 are both 1.
- R7: Control bit 0 drives eng_enable, bit 13 drives ioc_irq_en and bit 14 drives tout_irq_en. Bits 18:16 drive sample_width (0=8, 1=16, 2=20, 3=24, 4=32 bits), bits 19 upward drive active_ch, and all of these read back at 0x10.
- R8: Reads of unmapped or misaligned offsets return 0, and writes to them change no register.
- R9: A chsts_valid pulse latches word i of chsts_data (bits 32i+31:32i) at offset 0x2C+4i and sets status bit 29.
- R10: Offset 0x28 reads the sum of xfer_bytes over all xfer_adv pulses since the last reset.
- R11: Offsets 0x18, 0x1C, 0x20, 0x24 and 0x44 are plain 32-bit read/write registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| period_done | input | 1 | Period-complete pulse from the engine |
| chsts_valid | input | 1 | Channel-status capture pulse |
| chsts_data | input | 32*NUM_CS | Channel-status words to capture |
| xfer_adv | input | 1 | Transfer step pulse |
| xfer_bytes | input | INC_W | Bytes moved in this step |
| eng_enable | output | 1 | Run enable to the engine |
| eng_reset | output | 1 | Soft reset in progress |
| ioc_irq_en | output | 1 | Period-complete interrupt enable |
| tout_irq_en | output | 1 | Timeout interrupt enable |
| sample_width | output | 3 | Sample-width code |
| active_ch | output | CH_W | Active channel count |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block as a stream-to-memory instance, with HAS_M2S=0, S2M_MODE=1, S2M_PLANAR=1, S2M_MAXCH=8 and M2S_MAXCH=2. These values make the configuration word mix set and clear presence bits with non-zero fields on both halves. NUM_CS=6 fills the channel-status window right up to the bytes-per-channel register, so an off-by-one in that decode reaches an observable register. RST_CYCLES=16 lets the bench count the reset window edge by edge and push period-done pulses and enable writes into the middle of it.

// File: rtl/audio_rb_pkg.sv
package audio_rb_pkg;
    localparam int RB_ADDR_W = 8;

    localparam logic [RB_ADDR_W-1:0] OFS_CFG    = 8'h04;
    localparam logic [RB_ADDR_W-1:0] OFS_CTRL   = 8'h10;
    localparam logic [RB_ADDR_W-1:0] OFS_STS    = 8'h14;
    localparam logic [RB_ADDR_W-1:0] OFS_FSMUL  = 8'h18;
    localparam logic [RB_ADDR_W-1:0] OFS_PERIOD = 8'h1C;
    localparam logic [RB_ADDR_W-1:0] OFS_BUFLO  = 8'h20;
    localparam logic [RB_ADDR_W-1:0] OFS_BUFHI  = 8'h24;
    localparam logic [RB_ADDR_W-1:0] OFS_XCNT   = 8'h28;
    localparam logic [RB_ADDR_W-1:0] OFS_CSW0   = 8'h2C;
    localparam logic [RB_ADDR_W-1:0] OFS_BPC    = 8'h44;

    localparam int CB_EN      = 0;
    localparam int CB_SRST    = 1;
    localparam int CB_IOC_IE  = 13;
    localparam int CB_TOUT_IE = 14;
    localparam int CB_WID_LSB = 16;
    localparam int CB_ACH_LSB = 19;

    localparam int SB_IOC = 31;
    localparam int SB_CSV = 29;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_RESET = 1'b1
    } seq_state_t;
endpackage

// File: rtl/audio_rb_rstseq.sv
module audio_rb_rstseq
    import audio_rb_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = (RST_CYCLES > 2) ? $clog2(RST_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(RST_CYCLES - 1);

    seq_state_t state_q, state_d;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:  if (start) state_d = SEQ_RESET;
            SEQ_RESET: if (cnt_q == LAST) state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (state_q == SEQ_IDLE)   cnt_q <= '0;
        else                            cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        busy = (state_q == SEQ_RESET);
    end

    p_rst_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_RESET && cnt_q == LAST) |=> (state_q == SEQ_IDLE));
    p_rst_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_RESET && cnt_q != LAST) |=> (state_q == SEQ_RESET));
endmodule

// File: rtl/audio_rb_status.sv
module audio_rb_status (
    input  logic clk,
    input  logic rst_n,
    input  logic seq_busy,
    input  logic period_done,
    input  logic csv_pulse,
    input  logic w1c_ioc,
    input  logic ioc_ie,
    output logic sts_ioc,
    output logic sts_csv,
    output logic irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           sts_ioc <= 1'b0;
        else if (seq_busy)    sts_ioc <= 1'b0;
        else if (period_done) sts_ioc <= 1'b1;
        else if (w1c_ioc)     sts_ioc <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         sts_csv <= 1'b0;
        else if (seq_busy)  sts_csv <= 1'b0;
        else if (csv_pulse) sts_csv <= 1'b1;
    end

    always_comb irq = sts_ioc & ioc_ie;

    p_ioc_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (period_done && !seq_busy) |=> sts_ioc);
    p_ioc_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_ioc && !w1c_ioc && !seq_busy) |=> sts_ioc);
endmodule

// File: rtl/audio_dma_regbank.sv
module audio_dma_regbank
    import audio_rb_pkg::*;
#(
    parameter int RST_CYCLES = 16,
    parameter int NUM_CS     = 6,
    parameter int INC_W      = 16,
    parameter int CH_W       = 4,
    parameter int HAS_M2S    = 1,
    parameter int HAS_S2M    = 1,
    parameter int M2S_MAXCH  = 2,
    parameter int S2M_MAXCH  = 2,
    parameter int M2S_MODE   = 0,
    parameter int S2M_MODE   = 0,
    parameter int M2S_PLANAR = 0,
    parameter int S2M_PLANAR = 0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [RB_ADDR_W-1:0]   bus_addr,
    input  logic                   bus_wr,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    input  logic                   period_done,
    input  logic                   chsts_valid,
    input  logic [32*NUM_CS-1:0]   chsts_data,
    input  logic                   xfer_adv,
    input  logic [INC_W-1:0]       xfer_bytes,
    output logic                   eng_enable,
    output logic                   eng_reset,
    output logic                   ioc_irq_en,
    output logic                   tout_irq_en,
    output logic [2:0]             sample_width,
    output logic [CH_W-1:0]        active_ch,
    output logic                   irq
);
    localparam logic [31:0] CFG_WORD =
          ((32'(HAS_S2M)    & 32'h1) << 31)
        | ((32'(S2M_MODE)   & 32'h3) << 29)
        | ((32'(S2M_PLANAR) & 32'h1) << 28)
        | ((32'(S2M_MAXCH)  & 32'hF) << 24)
        | ((32'(HAS_M2S)    & 32'h1) << 15)
        | ((32'(M2S_MODE)   & 32'h3) << 13)
        | ((32'(M2S_PLANAR) & 32'h1) << 12)
        | ((32'(M2S_MAXCH)  & 32'hF) << 8);

    logic wr_ctrl, wr_sts, seq_busy, seq_start;
    logic sts_ioc, sts_csv;
    logic en_q, ioc_ie_q, tout_ie_q;
    logic [2:0] wid_q;
    logic [CH_W-1:0] ach_q;
    logic [31:0] fsmul_q, period_q, buflo_q, bufhi_q, bpc_q, xcnt_q;
    logic [31:0] cs_q [NUM_CS];
    logic [31:0] ctrl_rd, cs_rd;

    assign wr_ctrl   = bus_wr && (bus_addr == OFS_CTRL);
    assign wr_sts    = bus_wr && (bus_addr == OFS_STS);
    assign seq_start = wr_ctrl && bus_wdata[CB_SRST];

    audio_rb_rstseq #(.RST_CYCLES(RST_CYCLES)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (seq_start),
        .busy  (seq_busy)
    );

    audio_rb_status u_sts (
        .clk         (clk),
        .rst_n       (rst_n),
        .seq_busy    (seq_busy),
        .period_done (period_done),
        .csv_pulse   (chsts_valid),
        .w1c_ioc     (wr_sts && bus_wdata[SB_IOC]),
        .ioc_ie      (ioc_ie_q),
        .sts_ioc     (sts_ioc),
        .sts_csv     (sts_csv),
        .irq         (irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            ioc_ie_q  <= 1'b0;
            tout_ie_q <= 1'b0;
            wid_q     <= '0;
            ach_q     <= '0;
        end else begin
            if (wr_ctrl) begin
                ioc_ie_q  <= bus_wdata[CB_IOC_IE];
                tout_ie_q <= bus_wdata[CB_TOUT_IE];
                wid_q     <= bus_wdata[CB_WID_LSB +: 3];
                ach_q     <= bus_wdata[CB_ACH_LSB +: CH_W];
            end
            if (seq_busy)     en_q <= 1'b0;
            else if (wr_ctrl) en_q <= bus_wdata[CB_EN] & ~bus_wdata[CB_SRST];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsmul_q  <= '0;
            period_q <= '0;
            buflo_q  <= '0;
            bufhi_q  <= '0;
            bpc_q    <= '0;
        end else if (bus_wr) begin
            if (bus_addr == OFS_FSMUL)  fsmul_q  <= bus_wdata;
            if (bus_addr == OFS_PERIOD) period_q <= bus_wdata;
            if (bus_addr == OFS_BUFLO)  buflo_q  <= bus_wdata;
            if (bus_addr == OFS_BUFHI)  bufhi_q  <= bus_wdata;
            if (bus_addr == OFS_BPC)    bpc_q    <= bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        xcnt_q <= '0;
        else if (seq_busy) xcnt_q <= '0;
        else if (xfer_adv) xcnt_q <= xcnt_q + 32'(xfer_bytes);
    end

    for (genvar gi = 0; gi < NUM_CS; gi++) begin : g_csw
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       cs_q[gi] <= '0;
            else if (chsts_valid && !seq_busy) cs_q[gi] <= chsts_data[32*gi +: 32];
        end
    end

    always_comb begin
        ctrl_rd = '0;
        ctrl_rd[CB_EN]                = en_q;
        ctrl_rd[CB_SRST]              = seq_busy;
        ctrl_rd[CB_IOC_IE]            = ioc_ie_q;
        ctrl_rd[CB_TOUT_IE]           = tout_ie_q;
        ctrl_rd[CB_WID_LSB +: 3]      = wid_q;
        ctrl_rd[CB_ACH_LSB +: CH_W]   = ach_q;
    end

    always_comb begin
        cs_rd = '0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (bus_addr == OFS_CSW0 + RB_ADDR_W'(4 * i)) cs_rd = cs_q[i];
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_CFG:    bus_rdata = CFG_WORD;
            OFS_CTRL:   bus_rdata = ctrl_rd;
            OFS_STS:    bus_rdata = {sts_ioc, 1'b0, sts_csv, 29'b0};
            OFS_FSMUL:  bus_rdata = fsmul_q;
            OFS_PERIOD: bus_rdata = period_q;
            OFS_BUFLO:  bus_rdata = buflo_q;
            OFS_BUFHI:  bus_rdata = bufhi_q;
            OFS_XCNT:   bus_rdata = xcnt_q;
            OFS_BPC:    bus_rdata = bpc_q;
            default:    bus_rdata = cs_rd;
        endcase
    end

    assign eng_enable   = en_q;
    assign eng_reset    = seq_busy;
    assign ioc_irq_en   = ioc_ie_q;
    assign tout_irq_en  = tout_ie_q;
    assign sample_width = wid_q;
    assign active_ch    = ach_q;

    p_rst_clears_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        eng_reset |-> !eng_enable);
    p_rst_clears_cnt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_reset) |=> (xcnt_q == 32'd0));
    p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ioc_irq_en);
endmodule

// File: tb/audio_dma_regbank_tb.sv
module audio_dma_regbank_tb_top;
    localparam int CLK_P  = 10;
    localparam int NCS    = 6;
    localparam int IW     = 16;
    localparam int CHW    = 4;
    localparam logic [31:0] CFG_EXP = 32'hB800_0200;
    localparam logic [31:0] CTRL_V  = 32'h0013_6001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic period_done = 1'b0, chsts_valid = 1'b0, xfer_adv = 1'b0;
    logic [32*NCS-1:0] chsts_data = '0;
    logic [IW-1:0] xfer_bytes = '0;
    logic eng_enable, eng_reset, ioc_irq_en, tout_irq_en, irq;
    logic [2:0] sample_width;
    logic [CHW-1:0] active_ch;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [31:0] exp_q[$];
    string tag_q[$];
    event mon_ev;

    always #(CLK_P/2) clk = ~clk;

    audio_dma_regbank #(
        .RST_CYCLES(16), .NUM_CS(NCS), .INC_W(IW), .CH_W(CHW),
        .HAS_M2S(0), .HAS_S2M(1), .M2S_MAXCH(2), .S2M_MAXCH(8),
        .M2S_MODE(0), .S2M_MODE(1), .M2S_PLANAR(0), .S2M_PLANAR(1)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .period_done(period_done), .chsts_valid(chsts_valid),
        .chsts_data(chsts_data), .xfer_adv(xfer_adv), .xfer_bytes(xfer_bytes),
        .eng_enable(eng_enable), .eng_reset(eng_reset),
        .ioc_irq_en(ioc_irq_en), .tout_irq_en(tout_irq_en),
        .sample_width(sample_width), .active_ch(active_ch), .irq(irq)
    );

    // monitor: pops expected read data and compares with the bus
    initial begin
        forever begin
            @(mon_ev);
            begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (bus_rdata !== e) begin
                    fails++;
                    $display("FAIL %s addr=%h actual=%h expected=%h", t, bus_addr, bus_rdata, e);
                end
            end
        end
    end

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string t);
        bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        #1;
        ->mon_ev;
        #1;
    endtask

    task automatic port_chk(input logic [31:0] act, input logic [31:0] e, input string t);
        checks++;
        if (act !== e) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", t, act, e);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        wait_neg(3);
        rst_n = 1'b1;
        wait_neg(1);
        // R1 reset state
        rd_chk(8'h10, 32'h0, "R1 ctrl");
        rd_chk(8'h14, 32'h0, "R1 status");
        port_chk({29'b0, eng_enable, eng_reset, irq}, 32'h0, "R1 ports");
        // R2 config constant and read-only
        rd_chk(8'h04, CFG_EXP, "R2 config");
        wr(8'h04, 32'hFFFF_FFFF);
        rd_chk(8'h04, CFG_EXP, "R2 config after write");
        // R7 control fields
        wr(8'h10, CTRL_V);
        rd_chk(8'h10, CTRL_V, "R7 ctrl readback");
        port_chk({28'b0, eng_enable, ioc_irq_en, tout_irq_en, eng_reset}, 32'hE, "R7 enables");
        port_chk({29'b0, sample_width}, 32'd3, "R7 width");
        port_chk({28'b0, active_ch}, 32'd2, "R7 channels");
        // R11 plain registers
        wr(8'h18, 32'h0000_0100);
        wr(8'h1C, 32'h0004_0C00);
        wr(8'h20, 32'hDEAD_BEE0);
        wr(8'h24, 32'h0000_0012);
        wr(8'h44, 32'h0000_0600);
        rd_chk(8'h18, 32'h0000_0100, "R11 fs mult");
        rd_chk(8'h1C, 32'h0004_0C00, "R11 period");
        rd_chk(8'h20, 32'hDEAD_BEE0, "R11 buf lo");
        rd_chk(8'h24, 32'h0000_0012, "R11 buf hi");
        rd_chk(8'h44, 32'h0000_0600, "R11 bytes per ch");
        // R5 / R6 sticky flag and interrupt
        @(negedge clk); period_done = 1'b1;
        @(negedge clk); period_done = 1'b0;
        rd_chk(8'h14, 32'h8000_0000, "R5 flag set");
        port_chk({31'b0, irq}, 32'd1, "R6 irq high");
        wr(8'h14, 32'h0000_0000);
        rd_chk(8'h14, 32'h8000_0000, "R5 write zero keeps");
        wr(8'h10, CTRL_V & ~32'h2000);
        port_chk({31'b0, irq}, 32'd0, "R6 irq masked");
        wr(8'h10, CTRL_V);
        port_chk({31'b0, irq}, 32'd1, "R6 irq unmasked");
        wr(8'h14, 32'h8000_0000);
        rd_chk(8'h14, 32'h0, "R5 w1c");
        port_chk({31'b0, irq}, 32'd0, "R6 irq after clear");
        // R5 set wins over simultaneous clear
        @(negedge clk);
        bus_addr = 8'h14; bus_wdata = 32'h8000_0000; bus_wr = 1'b1; period_done = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; period_done = 1'b0;
        rd_chk(8'h14, 32'h8000_0000, "R5 set wins");
        // R10 transfer count
        @(negedge clk); xfer_adv = 1'b1; xfer_bytes = 16'd100;
        @(negedge clk); xfer_bytes = 16'd28;
        @(negedge clk); xfer_adv = 1'b0;
        rd_chk(8'h28, 32'd128, "R10 count");
        // R9 channel status capture
        for (int i = 0; i < NCS; i++) chsts_data[32*i +: 32] = 32'hC500_0000 + 32'(i);
        @(negedge clk); chsts_valid = 1'b1;
        @(negedge clk); chsts_valid = 1'b0;
        chsts_data = '0;
        for (int i = 0; i < NCS; i++)
            rd_chk(8'h2C + 8'(4*i), 32'hC500_0000 + 32'(i), "R9 word");
        rd_chk(8'h14, 32'hA000_0000, "R9 valid flag");
        // R8 unmapped
        wr(8'h08, 32'h1234_5678);
        wr(8'h48, 32'h1234_5678);
        wr(8'h12, 32'h1234_5678);
        rd_chk(8'h08, 32'h0, "R8 unmapped 08");
        rd_chk(8'h48, 32'h0, "R8 unmapped 48");
        rd_chk(8'h12, 32'h0, "R8 misaligned");
        rd_chk(8'h00, 32'h0, "R8 unmapped 00");
        rd_chk(8'h44, 32'h0000_0600, "R8 neighbour kept");
        rd_chk(8'h10, CTRL_V, "R8 ctrl kept");
        // R3 / R4 soft reset
        wr(8'h10, CTRL_V + 32'h1);
        port_chk({31'b0, eng_reset}, 32'd1, "R3 reset started");
        rd_chk(8'h10, 32'h0013_6002, "R3 bit reads one");
        wr(8'h10, CTRL_V);
        @(negedge clk); period_done = 1'b1;
        @(negedge clk); period_done = 1'b0;
        wait_neg(11);
        port_chk({30'b0, eng_reset, eng_enable}, 32'd2, "R3 still busy at 16");
        rd_chk(8'h10, 32'h0013_6002, "R4 enable write ignored");
        wait_neg(1);
        port_chk({31'b0, eng_reset}, 32'd0, "R3 self clear");
        rd_chk(8'h10, 32'h0013_6000, "R4 fields kept");
        rd_chk(8'h14, 32'h0, "R4 flags cleared");
        rd_chk(8'h28, 32'h0, "R4 count cleared");
        rd_chk(8'h1C, 32'h0004_0C00, "R4 setup kept");
        port_chk({31'b0, eng_enable}, 32'd0, "R4 enable cleared");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule